// File: doc/BRIEF.md
# Cell Read Port Selector

This block sits on the read side of four cell FIFOs that share one output word bus. An external poller picks the FIFO to drain by placing a port number on `port_addr_i` and pulsing `load_i`. When the picked FIFO reports a complete cell on its ready flag, the block pops that cell's words on consecutive clocks and presents them, one registered stage later, on `data_o` with `valid_o`.

The first word of each cell carries a one-cycle `soc_o` pulse. A transfer flag `xfer_o` rises with that first word and falls on the fourth word from the end. This warns the poller in time to name the next port. While a cell is being popped, loads are ignored, so the output never switches port in the middle of a cell. Each accepted load lets exactly one cell through. If the poller issues the next load in the cycle that shows the last word, the next cell follows with no gap.

The FIFOs are outside the block. Each is assumed to show its head word on its read-data slice (first-word fall-through) and to drop that word on a clock where its read enable is high.

Top module: `cell_read_sel`

## Requirements
- R1: While reset is held and directly after it, `valid_o`, `soc_o`, `xfer_o`, `data_o` and all of `rd_en_o` are 0.
- R2: `port_addr_i` is taken only in a cycle where `load_i` is 1 and no cell is being popped. A change of address without a load never starts a read from the newly addressed port.
- R3: If a load has already named a port, and that port's ready flag rises in cycle k, the first word of its cell is on `data_o` with `valid_o` high in cycle k+1.
- R4: If the load arrives in the same cycle as the named port's ready flag, or while that flag is already high, the first word is on `data_o` in the cycle after the load.
- R5: A cell of `cell_len_i` words is output on consecutive cycles in FIFO order, from the selected port only. At most one bit of `rd_en_o` is high in any cycle. Word i of the bench FIFO for port p reads `{p[1:0], i[15:0]}`.
- R6: `soc_o` is high for exactly one cycle per cell, together with the first word.
- R7: `xfer_o` is high with the first word and with every word whose zero-based index is below `cell_len_i - 4`, and low from index `cell_len_i - 4` on. It is never high without `valid_o`.
- R8: A load that arrives while the current cell is still being popped is ignored. The remaining words come from the current port, and the port named by the ignored load is not read afterwards.
- R9: A load arriving in the cycle that shows the last word of a cell is accepted. If the new port holds a cell, its first word follows in the next cycle with no idle cycle between the cells.
- R10: A load that names a port whose ready flag is low outputs no words until that flag rises.
- R11: Each accepted load releases at most one cell. After the cell, no further words are output until another load is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Strobe to take `port_addr_i` |
| port_addr_i | input | AW (2) | Port number to read next |
| cell_rdy_i | input | NPORT (4) | Per-FIFO flag: a complete cell is stored |
| cell_len_i | input | LEN_W (8) | Words per cell, at least 5, stable while a cell is being popped |
| rd_data_i | input | NPORT*DATA_W (72) | Head words of all FIFOs, port p at bits p*DATA_W upward |
| rd_en_o | output | NPORT (4) | Per-FIFO pop enable |
| data_o | output | DATA_W (18) | Output word |
| valid_o | output | 1 | `data_o` carries a cell word |
| soc_o | output | 1 | First word of a cell |
| xfer_o | output | 1 | Cell transfer in progress, drops four words before the end |

## Verification
The bench uses the default build: four ports, 18-bit words and an 8-bit length field. It sweeps every port against cell lengths 5 through 8. The shortest of these lengths makes the flag drop on the first word after the start-of-cell word. The longer ones move the drop point across the cell. Each port is paired with a neighbour that holds a cell but is not selected. This exercises mid-cell loads, address changes without a load, and back-to-back cells on every port pair used.

// File: rtl/cps_pkg.sv
package cps_pkg;
  typedef enum logic {
    RD_IDLE = 1'b0,
    RD_BUSY = 1'b1
  } rd_state_e;
endpackage

// File: rtl/cps_port_sel.sv
module cps_port_sel
  import cps_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int LEN_W = 8,
  localparam int AW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [NPORT-1:0] cell_rdy_i,
  input  logic [LEN_W-1:0] cell_len_i,
  output logic [NPORT-1:0] rd_en_o,
  output logic [AW-1:0]    port_o,
  output logic             pop_o,
  output logic             first_o,
  output logic [LEN_W-1:0] idx_o,
  output logic [LEN_W-1:0] len_o,
  output logic             busy_o
);
  rd_state_e        state_q;
  logic [AW-1:0]    sel_q, sel_nxt;
  logic             arm_q, arm_nxt;
  logic [LEN_W-1:0] cnt_q, len_q;
  logic             busy, take, start, pop, last;
  logic [LEN_W-1:0] idx, len_cur;

  always_comb begin
    busy    = (state_q == RD_BUSY);
    // loads only count between cells
    take    = !busy && load_i;
    sel_nxt = take ? addr_i : sel_q;
    arm_nxt = arm_q || take;
    start   = !busy && arm_nxt && cell_rdy_i[sel_nxt];
    pop     = start || busy;
    idx     = busy ? cnt_q : '0;
    len_cur = busy ? len_q : cell_len_i;
    last    = pop && (idx == len_cur - LEN_W'(1));
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_ren
    assign rd_en_o[g] = pop && (sel_nxt == AW'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RD_IDLE;
      sel_q   <= '0;
      arm_q   <= 1'b0;
      cnt_q   <= '0;
      len_q   <= '0;
    end else begin
      sel_q   <= sel_nxt;
      arm_q   <= start ? 1'b0 : arm_nxt;
      state_q <= (pop && !last) ? RD_BUSY : RD_IDLE;
      if (pop) cnt_q <= idx + LEN_W'(1);
      if (start) len_q <= cell_len_i;
    end
  end

  assign port_o  = sel_nxt;
  assign pop_o   = pop;
  assign first_o = start;
  assign idx_o   = idx;
  assign len_o   = len_cur;
  assign busy_o  = busy;
endmodule

// File: rtl/cps_out_stage.sv
module cps_out_stage #(
  parameter int NPORT  = 4,
  parameter int DATA_W = 18,
  parameter int LEN_W  = 8,
  parameter int TAIL   = 4,
  localparam int AW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NPORT*DATA_W-1:0] rd_data_i,
  input  logic [AW-1:0]           port_i,
  input  logic                    pop_i,
  input  logic                    first_i,
  input  logic [LEN_W-1:0]        idx_i,
  input  logic [LEN_W-1:0]        len_i,
  output logic [DATA_W-1:0]       data_o,
  output logic                    valid_o,
  output logic                    soc_o,
  output logic                    xfer_o
);
  logic [DATA_W-1:0] word_sel;
  logic              flag_nxt;

  always_comb begin
    word_sel = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (port_i == AW'(p)) word_sel = rd_data_i[p*DATA_W +: DATA_W];
    end
    // flag stays up until the TAIL-th word from the end
    flag_nxt = pop_i && (first_i ||
               (({1'b0, idx_i} + (LEN_W+1)'(TAIL)) < {1'b0, len_i}));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      soc_o   <= 1'b0;
      xfer_o  <= 1'b0;
    end else begin
      valid_o <= pop_i;
      soc_o   <= first_i;
      xfer_o  <= flag_nxt;
      if (pop_i) data_o <= word_sel;
    end
  end
endmodule

// File: rtl/cell_read_sel.sv
module cell_read_sel #(
  parameter int NPORT  = 4,
  parameter int DATA_W = 18,
  parameter int LEN_W  = 8,
  parameter int TAIL   = 4,
  localparam int AW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [AW-1:0]           port_addr_i,
  input  logic [NPORT-1:0]        cell_rdy_i,
  input  logic [LEN_W-1:0]        cell_len_i,
  input  logic [NPORT*DATA_W-1:0] rd_data_i,
  output logic [NPORT-1:0]        rd_en_o,
  output logic [DATA_W-1:0]       data_o,
  output logic                    valid_o,
  output logic                    soc_o,
  output logic                    xfer_o
);
  logic [AW-1:0]    port_w;
  logic             pop_w, first_w, busy_w;
  logic [LEN_W-1:0] idx_w, len_w;

  cps_port_sel #(
    .NPORT(NPORT),
    .LEN_W(LEN_W)
  ) i_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .addr_i    (port_addr_i),
    .cell_rdy_i(cell_rdy_i),
    .cell_len_i(cell_len_i),
    .rd_en_o   (rd_en_o),
    .port_o    (port_w),
    .pop_o     (pop_w),
    .first_o   (first_w),
    .idx_o     (idx_w),
    .len_o     (len_w),
    .busy_o    (busy_w)
  );

  cps_out_stage #(
    .NPORT (NPORT),
    .DATA_W(DATA_W),
    .LEN_W (LEN_W),
    .TAIL  (TAIL)
  ) i_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_data_i(rd_data_i),
    .port_i   (port_w),
    .pop_i    (pop_w),
    .first_i  (first_w),
    .idx_i    (idx_w),
    .len_i    (len_w),
    .data_o   (data_o),
    .valid_o  (valid_o),
    .soc_o    (soc_o),
    .xfer_o   (xfer_o)
  );
endmodule

// File: rtl/cps_chk.sv
module cps_chk #(
  parameter int NPORT = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NPORT-1:0] rd_en_i,
  input logic             valid_i,
  input logic             soc_i,
  input logic             xfer_i,
  input logic             busy_i
);
  AST_ONE_READER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_en_i)); // R5
  AST_SOC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soc_i |=> !soc_i); // R6
  AST_SOC_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soc_i |-> (valid_i && xfer_i)); // R7
  AST_XFER_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i |-> valid_i); // R7
  AST_SOC_FROM_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soc_i |-> $past(|rd_en_i)); // R3
  AST_NO_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (rd_en_i == $past(rd_en_i))); // R8
endmodule

bind cell_read_sel cps_chk #(.NPORT(NPORT)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .rd_en_i(rd_en_o),
  .valid_i(valid_o),
  .soc_i  (soc_o),
  .xfer_i (xfer_o),
  .busy_i (busy_w)
);

// File: tb/test_cell_read_sel.sv
`timescale 1ns/1ps
module test_cell_read_sel;
  localparam int NP = 4, DW = 18, LW = 8;

  logic              clk = 1'b0, rst_n = 1'b0;
  logic              load = 1'b0;
  logic [1:0]        addr = '0;
  logic [NP-1:0]     rdy;
  logic [LW-1:0]     clen = LW'(5);
  logic [NP*DW-1:0]  rdata;
  logic [NP-1:0]     ren;
  logic [DW-1:0]     dout;
  logic              valid, soc, xfer;

  int cyc = 0, checks = 0, errors = 0, n_log = 0;
  int added[NP], popped[NP], exp_head[NP];
  logic [DW-1:0] wd[64];
  bit ws[64], wx[64];
  int wc[64];
  bit done = 0;

  always #4 clk = ~clk;

  cell_read_sel i_cell_read_sel (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .port_addr_i(addr),
    .cell_rdy_i(rdy), .cell_len_i(clen), .rd_data_i(rdata),
    .rd_en_o(ren), .data_o(dout), .valid_o(valid), .soc_o(soc), .xfer_o(xfer));

  // behavioural FIFO stubs: head word is {port, pop count}
  always_comb begin
    for (int p = 0; p < NP; p++) begin
      rdata[p*DW +: DW] = {2'(p), 16'(popped[p])};
      rdy[p] = (added[p] - popped[p]) >= int'(clen);
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    for (int p = 0; p < NP; p++) popped[p] <= popped[p] + (ren[p] ? 1 : 0);
  end

  always @(negedge clk) begin
    if (valid && n_log < 64) begin
      wd[n_log] = dout; ws[n_log] = soc; wx[n_log] = xfer; wc[n_log] = cyc;
      n_log = n_log + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_load(input int p);
    load = 1'b1; addr = 2'(p);
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic vcell(input int li, input int p, input int len, input int c0, input int base);
    for (int i = 0; i < len; i++) begin
      logic [DW-1:0] e;
      e = {2'(p), 16'(base + i)};
      chk(wc[li+i] == c0 + i, "R5 cycle", wc[li+i], c0 + i);
      chk(wd[li+i] == e, "R5 data", int'(wd[li+i]), int'(e));
      chk(ws[li+i] == (i == 0), "R6 soc", int'(ws[li+i]), int'(i == 0));
      chk(wx[li+i] == (i < len - 4), "R7 xfer", int'(wx[li+i]), int'(i < len - 4));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int k, m, q;
    tick(3);
    // R1: reset state
    chk({valid, soc, xfer} == 3'b0, "R1 flags", int'({valid, soc, xfer}), 0);
    chk(dout == '0, "R1 data", int'(dout), 0);
    chk(ren == '0, "R1 rd_en", int'(ren), 0);
    rst_n = 1'b1;
    tick(2);
    chk({valid, soc, xfer} == 3'b0, "R1 after release", int'({valid, soc, xfer}), 0);

    for (int p = 0; p < NP; p++) begin
      for (int len = 5; len <= 8; len++) begin
        // flow A: armed wait, stray address, mid-cell load, single cell
        clen = LW'(len); n_log = 0; q = (p + 1) % NP;
        pulse_load(p);
        added[q] += len;
        for (int j = 0; j < 3; j++) begin
          addr = 2'(q + j);
          @(negedge clk);
        end
        chk(n_log == 0, "R10 no words while not ready", n_log, 0);
        chk(n_log == 0, "R2 address change without load", n_log, 0);
        k = cyc;
        added[p] += len;
        tick(2);
        pulse_load(q);
        tick(len + 3);
        chk(n_log == len, "R8 word count", n_log, len);
        chk(wc[0] == k + 1, "R3 first word", wc[0], k + 1);
        vcell(0, p, len, k + 1, exp_head[p]);
        exp_head[p] += len;
        tick(3);
        chk(n_log == len, "R11 one cell per load", n_log, len);
        // drain q: its flag is already high at the load
        m = cyc;
        pulse_load(q);
        tick(len + 2);
        chk(n_log == 2 * len, "R4 drained count", n_log, 2 * len);
        chk(wc[len] == m + 1, "R4 ready already high", wc[len], m + 1);
        vcell(len, q, len, m + 1, exp_head[q]);
        exp_head[q] += len;

        // flow B: load with ready rise, back-to-back cell
        n_log = 0; q = (p + 2) % NP;
        k = cyc;
        added[p] += len;
        pulse_load(p);
        added[q] += len;
        tick(len - 1);
        pulse_load(q);
        tick(len + 3);
        chk(n_log == 2 * len, "R9 word count", n_log, 2 * len);
        chk(wc[0] == k + 1, "R4 load with ready", wc[0], k + 1);
        vcell(0, p, len, k + 1, exp_head[p]);
        exp_head[p] += len;
        chk(wc[len] == k + len + 1, "R9 back to back", wc[len], k + len + 1);
        vcell(len, q, len, k + len + 1, exp_head[q]);
        exp_head[q] += len;
        tick(2);
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule